// File: doc/BRIEF.md
# SDRAM Read-Return Latency and Byte-Mask Datapath

This block sits on the data side of a 16-bit SDRAM controller, just behind the burst sequencer. Each cycle the sequencer may raise a read beat or a write beat, and each beat carries a 2-bit bank tag. Read beats enter a short shift pipeline. They come out as a read-valid pulse, with their bank tag, exactly 2 or 3 cycles later. A one-bit run-time setting picks between the two latencies. Write beats pass through in the same cycle. On the way through, the per-byte mask bits turn into byte enables and gate the outgoing write data.

When the sequencer stops a read burst or overrides it with a new command, it pulses a stop strobe. Every read beat still in flight is then dropped, so no stale data is flagged valid. A read beat that arrives in the stop cycle itself belongs to the new burst and is kept. The byte mask also applies to returning read data with a fixed two-cycle delay. A latency change requested while beats are in flight is held off until the pipeline is idle.

Top module: `sdram_beat_path`

## Requirements
- R1: With the latency setting at 0, a read beat presented in cycle N produces rdValid high in cycle N+2, and in no other cycle.
- R2: With the latency setting at 1, a read beat presented in cycle N produces rdValid high in cycle N+3, and in no other cycle.
- R3: A new latency setting takes effect only after a clock edge at which no read beat is in flight and no read beat is presented. A change made while beats are pending is ignored until then. Each beat uses the latency in effect in its own cycle.
- R4: rdBank in the cycle rdValid is high equals the bank tag presented with that read beat.
- R5: A stop strobe in cycle S discards every read beat presented before S whose return cycle is later than S. Beats returning in cycle S or earlier are unaffected. A read beat presented in cycle S itself is kept.
- R6: wrByteEn[b] is high in the same cycle exactly when wrBeat is high and byteMask[b] is low. Bit 1 is the upper byte (data bits 15:8) and bit 0 is the lower byte (bits 7:0). A mask bit of 1 blocks its byte.
- R7: wrDataOut carries the wrData byte on every enabled byte lane and zero on every other lane, in the same cycle.
- R8: In a cycle where rdValid is high, rdByteValid[b] is high exactly when byteMask[b] was low two cycles earlier. rdByteValid is all zero whenever rdValid is low.
- R9: Reset empties the read pipeline. rdValid stays low during reset and until a new read beat has come through. After reset, the latency setting is loaded at the first idle edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdBeat | input | 1 | Read beat strobe from the burst sequencer |
| beatBank | input | 2 | Bank tag of the current read beat |
| burstStop | input | 1 | Terminate or override: drop in-flight read beats |
| latSel | input | 1 | Requested read latency: 0 selects 2 cycles, 1 selects 3 |
| byteMask | input | 2 | Per-byte mask, bit 1 upper byte, bit 0 lower byte |
| wrBeat | input | 1 | Write beat strobe |
| wrData | input | 16 | Write data for the current beat |
| rdValid | output | 1 | Read data returned this cycle |
| rdBank | output | 2 | Bank tag of the returning read beat |
| rdByteValid | output | 2 | Per-byte validity of the returning read data |
| wrByteEn | output | 2 | Per-byte write enable for the current beat |
| wrDataOut | output | 16 | Write data with blocked bytes forced to zero |

## Verification
The bench builds the block with its default parameters: a 16-bit data path (two byte lanes) and a minimum latency of 2, so the stage chain is three deep. This brings both tap positions within reach. It also makes the stop strobe reachable while a beat sits in each stage, including the output stage in the stop cycle. Because the mask delay line is two stages long, at latency 3 the mask that counts is the one from the cycle after the beat, not the beat's own. The bench exercises exactly that case.

// File: rtl/sdram_beat_pkg.sv
package sdram_beat_pkg;
  localparam int BANK_W = 2;

  // Strobes the control side hands to the datapath each cycle
  typedef struct packed {
    logic load;   // a read beat enters stage 0
    logic flush;  // drop everything already in flight
    logic deep;   // use the longer read latency tap
  } beatCtl_t;

  // One slot of the read-return pipeline
  typedef struct packed {
    logic              valid;
    logic [BANK_W-1:0] bank;
  } rdStage_t;
endpackage

// File: rtl/sdram_beat_ctl.sv
module sdram_beat_ctl
  import sdram_beat_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdBeat,
  input  logic     burstStop,
  input  logic     latSel,
  input  logic     pipeBusy,
  output beatCtl_t ctl
);
  logic curDeep;

  // Latency register only follows the request when nothing is in flight
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      curDeep <= 1'b0;
    else if (!pipeBusy && !rdBeat)
      curDeep <= latSel;
  end

  always_comb begin
    ctl.load  = rdBeat;
    ctl.flush = burstStop;
    ctl.deep  = curDeep;
  end
endmodule

// File: rtl/sdram_beat_dp.sv
module sdram_beat_dp
  import sdram_beat_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int MIN_LAT  = 2,
  parameter int MASK_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  beatCtl_t              ctl,
  input  logic [BANK_W-1:0]     beatBank,
  input  logic [DATA_W/8-1:0]   byteMask,
  input  logic                  wrBeat,
  input  logic [DATA_W-1:0]     wrData,
  output logic                  pipeBusy,
  output logic                  rdValid,
  output logic [BANK_W-1:0]     rdBank,
  output logic [DATA_W/8-1:0]   rdByteValid,
  output logic [DATA_W/8-1:0]   wrByteEn,
  output logic [DATA_W-1:0]     wrDataOut
);
  localparam int BYTES   = DATA_W / 8;
  localparam int MAX_LAT = MIN_LAT + 1;

  rdStage_t [MAX_LAT-1:0]            stg;
  logic     [MASK_LAT-1:0][BYTES-1:0] maskPipe;
  rdStage_t                           tapOut;

  // Stage k holds a beat that was presented k+1 cycles ago
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg      <= '0;
      maskPipe <= '0;
    end else begin
      stg[0] <= ctl.load ? {1'b1, beatBank} : '0;
      for (int i = 1; i < MAX_LAT; i++) begin
        if (ctl.flush || (i == MAX_LAT - 1 && !ctl.deep))
          stg[i] <= '0;
        else
          stg[i] <= stg[i-1];
      end
      maskPipe[0] <= byteMask;
      for (int j = 1; j < MASK_LAT; j++)
        maskPipe[j] <= maskPipe[j-1];
    end
  end

  always_comb begin
    pipeBusy = 1'b0;
    for (int i = 0; i < MAX_LAT; i++)
      pipeBusy = pipeBusy | stg[i].valid;
  end

  assign tapOut      = ctl.deep ? stg[MAX_LAT-1] : stg[MIN_LAT-1];
  assign rdValid     = tapOut.valid;
  assign rdBank      = tapOut.bank;
  assign rdByteValid = {BYTES{tapOut.valid}} & ~maskPipe[MASK_LAT-1];

  // Write lanes: zero latency, mask bit 1 blocks the lane
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign wrByteEn[b]          = wrBeat & ~byteMask[b];
    assign wrDataOut[b*8 +: 8]  = wrByteEn[b] ? wrData[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sdram_beat_path.sv
module sdram_beat_path
  import sdram_beat_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_LAT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdBeat,
  input  logic [BANK_W-1:0]   beatBank,
  input  logic                burstStop,
  input  logic                latSel,
  input  logic [DATA_W/8-1:0] byteMask,
  input  logic                wrBeat,
  input  logic [DATA_W-1:0]   wrData,
  output logic                rdValid,
  output logic [BANK_W-1:0]   rdBank,
  output logic [DATA_W/8-1:0] rdByteValid,
  output logic [DATA_W/8-1:0] wrByteEn,
  output logic [DATA_W-1:0]   wrDataOut
);
  beatCtl_t ctl;
  logic     pipeBusy;

  sdram_beat_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .rdBeat    (rdBeat),
    .burstStop (burstStop),
    .latSel    (latSel),
    .pipeBusy  (pipeBusy),
    .ctl       (ctl)
  );

  sdram_beat_dp #(
    .DATA_W  (DATA_W),
    .MIN_LAT (MIN_LAT),
    .MASK_LAT(2)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .beatBank    (beatBank),
    .byteMask    (byteMask),
    .wrBeat      (wrBeat),
    .wrData      (wrData),
    .pipeBusy    (pipeBusy),
    .rdValid     (rdValid),
    .rdBank      (rdBank),
    .rdByteValid (rdByteValid),
    .wrByteEn    (wrByteEn),
    .wrDataOut   (wrDataOut)
  );
endmodule

// File: rtl/sdram_beat_path_chk.sv
module sdram_beat_path_chk #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdBeat,
  input logic                burstStop,
  input logic [DATA_W/8-1:0] byteMask,
  input logic                wrBeat,
  input logic                rdValid,
  input logic [DATA_W/8-1:0] rdByteValid,
  input logic [DATA_W/8-1:0] wrByteEn
);
  // R1 R2
  lat_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(rdBeat, 2) || $past(rdBeat, 3)));

  // R5
  stop_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstStop |=> !rdValid);

  // R6
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|wrByteEn) |-> wrBeat);

  // R6
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrByteEn & byteMask) == '0);

  // R8
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ((rdByteValid & $past(byteMask, 2)) == '0));

  // R8
  rd_byte_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rdByteValid) |-> rdValid);

  // R9
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rst_quiet_chk: assert (!rdValid);
    end
  end
endmodule

bind sdram_beat_path sdram_beat_path_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sdram_beat_path_bench.sv
module sdram_beat_path_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rdBeat, burstStop, latSel, wrBeat;
  logic [1:0]  beatBank, byteMask;
  logic [15:0] wrData;
  logic        rdValid;
  logic [1:0]  rdBank, rdByteValid, wrByteEn;
  logic [15:0] wrDataOut;

  sdram_beat_path u_sdram_beat_path (
    .clk(clk), .rstN(rstN), .rdBeat(rdBeat), .beatBank(beatBank),
    .burstStop(burstStop), .latSel(latSel), .byteMask(byteMask),
    .wrBeat(wrBeat), .wrData(wrData), .rdValid(rdValid), .rdBank(rdBank),
    .rdByteValid(rdByteValid), .wrByteEn(wrByteEn), .wrDataOut(wrDataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int due; logic [1:0] bank; } exp_t;
  exp_t       sb[$];
  logic [1:0] maskHist [0:4095];
  int         cyc = 0;
  int         nChecks = 0;
  int         nErrors = 0;
  bit         done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Driver: one call per cycle, pushes expected read returns
  task automatic step(input bit rd, input bit [1:0] bk, input bit [1:0] msk,
                      input bit stop, input bit lsel, input int lat,
                      input bit wr = 1'b0, input bit [15:0] d = 16'h0);
    logic [1:0]  expEn;
    logic [15:0] expD;
    @(negedge clk);
    rdBeat = rd; beatBank = bk; byteMask = msk; burstStop = stop;
    latSel = lsel; wrBeat = wr; wrData = d;
    if (stop)
      while (sb.size() > 0 && sb[$].due > cyc) void'(sb.pop_back());
    if (rd) sb.push_back('{cyc + lat, bk});
    #1;
    expEn = wr ? ~msk : 2'b00;
    expD  = {expEn[1] ? d[15:8] : 8'h00, expEn[0] ? d[7:0] : 8'h00};
    chk(wrByteEn == expEn, "R6 write byte enable", wrByteEn, expEn);
    chk(wrDataOut == expD, "R7 masked write data", wrDataOut, expD);
  endtask

  task automatic idle(input int n, input bit lsel, input int lat);
    for (int k = 0; k < n; k++) step(1'b0, 2'd0, 2'd0, 1'b0, lsel, lat);
  endtask

  // Monitor: compare returns against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      maskHist[cyc] = byteMask;
      cyc++;
      #1;
      if (!rstN) begin
        chk(rdValid == 1'b0, "R9 quiet in reset", rdValid, 0);
      end else if (sb.size() > 0 && sb[0].due == cyc) begin
        logic [1:0] expBv;
        expBv = ~maskHist[cyc-2];
        chk(rdValid == 1'b1, "R1/R2 valid on due cycle", rdValid, 1);
        chk(rdBank == sb[0].bank, "R4 bank tag", rdBank, sb[0].bank);
        chk(rdByteValid == expBv, "R8 read byte valid", rdByteValid, expBv);
        void'(sb.pop_front());
      end else begin
        chk(rdValid == 1'b0, "R5 no stray valid", rdValid, 0);
        chk(rdByteValid == 2'b00, "R8 byte valid idle", rdByteValid, 0);
      end
    end
  end

  initial begin
    rstN = 1'b0; rdBeat = 0; burstStop = 0; latSel = 0; wrBeat = 0;
    beatBank = 0; byteMask = 0; wrData = 0;
    repeat (3) @(negedge clk);
    chk(rdValid == 1'b0 && rdByteValid == 2'b00, "R9 reset state", rdValid, 0);
    rstN = 1'b1;
    idle(3, 1'b0, 2);

    // R1 R4: back-to-back reads at latency 2
    step(1, 2'd0, 2'b00, 0, 0, 2);
    step(1, 2'd1, 2'b00, 0, 0, 2);
    step(1, 2'd2, 2'b00, 0, 0, 2);
    step(1, 2'd3, 2'b00, 0, 0, 2);
    idle(4, 0, 2);
    // R8: read masks at latency 2
    step(1, 2'd1, 2'b01, 0, 0, 2);
    step(1, 2'd2, 2'b10, 0, 0, 2);
    step(1, 2'd3, 2'b11, 0, 0, 2);
    step(0, 2'd0, 2'b10, 0, 0, 2);
    idle(4, 0, 2);

    // R6 R7: writes under every mask pattern
    step(0, 0, 2'b00, 0, 0, 2, 1'b1, 16'hA55A);
    step(0, 0, 2'b01, 0, 0, 2, 1'b1, 16'h1234);
    step(0, 0, 2'b10, 0, 0, 2, 1'b1, 16'hBEEF);
    step(0, 0, 2'b11, 0, 0, 2, 1'b1, 16'hFFFF);
    step(0, 0, 2'b00, 0, 0, 2, 1'b0, 16'hC3C3);
    idle(2, 0, 2);

    // R2 R8: switch to latency 3 while idle; mask counts one cycle after beat
    idle(3, 1, 3);
    step(1, 2'd2, 2'b11, 0, 1, 3);
    step(1, 2'd1, 2'b01, 0, 1, 3);
    step(1, 2'd3, 2'b10, 0, 1, 3);
    step(0, 2'd0, 2'b00, 0, 1, 3);
    idle(5, 1, 3);

    // R3: change requested while busy is ignored, applied once idle
    step(1, 2'd1, 2'b00, 0, 1, 3);
    step(0, 2'd0, 2'b00, 0, 0, 3);
    step(1, 2'd2, 2'b00, 0, 0, 3);
    idle(6, 0, 2);
    step(1, 2'd3, 2'b00, 0, 0, 2);
    idle(4, 0, 2);

    // R5: stop at latency 2 with a new beat in the stop cycle
    step(1, 2'd0, 2'b00, 0, 0, 2);
    step(1, 2'd1, 2'b00, 0, 0, 2);
    step(1, 2'd3, 2'b00, 1, 0, 2);
    idle(4, 0, 2);

    // R5: stop at latency 3 with three beats in flight
    idle(3, 1, 3);
    step(1, 2'd1, 2'b00, 0, 1, 3);
    step(1, 2'd2, 2'b00, 0, 1, 3);
    step(1, 2'd3, 2'b00, 0, 1, 3);
    step(0, 2'd0, 2'b00, 1, 1, 3);
    idle(5, 1, 3);

    // R9: reset with beats pending, then latency reloads from the setting
    step(1, 2'd2, 2'b00, 0, 1, 3);
    step(1, 2'd1, 2'b00, 0, 1, 3);
    @(negedge clk);
    rstN = 1'b0; rdBeat = 0; burstStop = 0;
    sb.delete();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(4, 1, 3);
    step(1, 2'd3, 2'b00, 0, 1, 3);
    idle(6, 1, 3);

    chk(sb.size() == 0, "R1/R2 all returns seen", sb.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule